// File: doc/BRIEF.md
# Byte-Lane Table Lookup Unit

This block performs a four-lane byte gather from a small table. The table is a bank of 64-bit entries loaded through a plain write port. A lookup request carries a 32-bit index word, a 32-bit default word, a table-length code and a base-entry number. Each byte of the index word is an independent byte address into the table. The four fetched bytes are packed into a 32-bit result, so lane k of the index produces lane k of the result.

A lane whose byte address falls outside the table length does not read the table. It returns the byte from the same lane of the default word. A caller can therefore chain lookups over longer tables, or merge a lookup into an existing value. A byte address is split in two: its upper bits name an entry counted from the base entry, and its lowest three bits name a byte inside that entry.

The lookup path is combinational from the request to the result register. The result and its valid strobe appear one clock after the request. The asynchronous active-low reset is released synchronously, two clocks after the reset pin rises.

Top module: `lane_table_lookup`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_data is 0, and every table entry reads as zero.
- R2: rsp_valid is 1 in exactly the cycle after each cycle in which req_valid is 1, and 0 in every other cycle.
- R3: Lane k (k = 0..3) uses index bits [8k+7:8k] and writes only result bits [8k+7:8k]. The lanes do not interact.
- R4: A lane is in range when its index byte, read as unsigned, is strictly less than (req_len_code+1)*8. That limit is 8, 16, 24 or 32 bytes.
- R5: An in-range lane returns byte idx[2:0] of table entry (req_base + idx[4:3]) mod 4. Byte 0 is bits [7:0] of the entry.
- R6: An out-of-range lane returns bits [8k+7:8k] of req_default. This includes index 255 and an index equal to the limit.
- R7: When wr_en is 1 at a clock edge, wr_data is stored in entry wr_addr.
- R8: A lookup in the same cycle as a write returns the table contents from before that write. The new value is visible to the next lookup.
- R9: rsp_data keeps its value in every cycle after which no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 2 | Entry written |
| wr_data | input | 64 | Value written |
| req_valid | input | 1 | Lookup request |
| req_index | input | 32 | Four byte indices |
| req_default | input | 32 | Bytes for out-of-range lanes |
| req_len_code | input | 2 | Table length: (code+1)*8 bytes |
| req_base | input | 2 | First table entry |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_data | output | 32 | Packed lookup result |

## Verification
The bench targets the range boundary in every lane: limit-1, the limit itself, and 255. An off-by-one compare would return a table byte for an index equal to the limit. A signed compare would let 255 read the table. It checks the default byte lane by lane, because swapped lanes would leak a neighbour's default byte. It also exercises a base offset that wraps past the last entry; a missing wrap would read the wrong entry or none. It checks a write issued in the same cycle as a lookup, where a bypass path would leak the new value early.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BSEL_W = 3;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lut_table_mem.sv
module lut_table_mem #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned ENT_AW = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ENT_AW-1:0]                wr_addr,
  input  logic [ENTRY_W-1:0]               wr_data,
  output logic [ENTRIES-1:0][ENTRY_W-1:0]  tbl
);
  logic [ENTRIES-1:0][ENTRY_W-1:0] tbl_q;
  logic [ENTRIES-1:0][ENTRY_W-1:0] tbl_d;
  logic [ENTRIES-1:0]              ent_we;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_comb begin
      ent_we[e] = wr_en && (wr_addr == ENT_AW'(e));
      tbl_d[e]  = ent_we[e] ? wr_data : tbl_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_q[e] <= '0;
      else        tbl_q[e] <= tbl_d[e];
    end
  end

  assign tbl = tbl_q;
endmodule

// File: rtl/lut_lane_sel.sv
module lut_lane_sel
  import lut_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned ENT_AW = $clog2(ENTRIES),
  localparam int unsigned BYTES  = ENTRY_W / BYTE_W,
  localparam int unsigned LIM_W  = BYTE_W + 1
) (
  input  logic [ENTRIES-1:0][ENTRY_W-1:0] tbl,
  input  byte_t                           idx,
  input  byte_t                           dflt,
  input  logic [LIM_W-1:0]                limit,
  input  logic [ENT_AW-1:0]               base,
  output byte_t                           res
);
  logic                           in_rng;
  logic [ENT_AW-1:0]              ent;
  logic [BSEL_W-1:0]              bsel;
  logic [BYTES-1:0][BYTE_W-1:0]   word;

  always_comb begin
    in_rng = {1'b0, idx} < limit;
    ent    = idx[BSEL_W +: ENT_AW] + base;
    bsel   = idx[BSEL_W-1:0];
    word   = tbl[ent];
    res    = in_rng ? word[bsel] : dflt;
  end
endmodule

// File: rtl/lane_table_lookup.sv
module lane_table_lookup
  import lut_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned ENT_AW = $clog2(ENTRIES),
  localparam int unsigned DATA_W = LANES * BYTE_W,
  localparam int unsigned LIM_W  = BYTE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ENT_AW-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               req_valid,
  input  logic [DATA_W-1:0]  req_index,
  input  logic [DATA_W-1:0]  req_default,
  input  logic [ENT_AW-1:0]  req_len_code,
  input  logic [ENT_AW-1:0]  req_base,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);
  logic [1:0]                       rst_sync_q;
  logic                             rst_sync_n;
  logic [ENTRIES-1:0][ENTRY_W-1:0]  tbl;
  logic [ENT_AW:0]                  len_plus;
  logic [LIM_W-1:0]                 limit;
  logic [DATA_W-1:0]                res_d;
  logic [DATA_W-1:0]                data_q;
  logic [DATA_W-1:0]                data_d;
  logic                             valid_q;
  logic                             valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  lut_table_mem #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tbl     (tbl)
  );

  always_comb begin
    len_plus = {1'b0, req_len_code} + 1'b1;
    limit    = LIM_W'(len_plus) << BSEL_W;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lut_lane_sel #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_sel (
      .tbl   (tbl),
      .idx   (req_index[k*BYTE_W +: BYTE_W]),
      .dflt  (req_default[k*BYTE_W +: BYTE_W]),
      .limit (limit),
      .base  (req_base),
      .res   (res_d[k*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    data_d  = req_valid ? res_d : data_q;
    valid_d = req_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign rsp_data  = data_q;
  assign rsp_valid = valid_q;
endmodule

// File: rtl/lane_table_lookup_chk.sv
module lane_table_lookup_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ENT_AW = 2
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 req_valid,
  input logic [LANES*8-1:0]   req_index,
  input logic [LANES*8-1:0]   req_default,
  input logic [ENT_AW-1:0]    req_len_code,
  input logic                 rsp_valid,
  input logic [LANES*8-1:0]   rsp_data
);
  logic [8:0] lim_chk;
  assign lim_chk = 9'((req_len_code + 1) * 8);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> $stable(rsp_data)); // R9

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_OOB_DEFAULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (req_valid && ({1'b0, req_index[k*8 +: 8]} >= lim_chk))
      |=> (rsp_data[k*8 +: 8] == $past(req_default[k*8 +: 8]))); // R6
  end
endmodule

bind lane_table_lookup lane_table_lookup_chk #(.LANES(LANES), .ENT_AW(ENT_AW)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .req_valid    (req_valid),
  .req_index    (req_index),
  .req_default  (req_default),
  .req_len_code (req_len_code),
  .rsp_valid    (rsp_valid),
  .rsp_data     (rsp_data)
);

// File: tb/lane_table_lookup_test.sv
module lane_table_lookup_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [63:0] wr_data;
  logic        req_valid;
  logic [31:0] req_index;
  logic [31:0] req_default;
  logic [1:0]  req_len_code;
  logic [1:0]  req_base;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] model [4];

  always #4 clk = ~clk;

  lane_table_lookup uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_index(req_index), .req_default(req_default),
    .req_len_code(req_len_code), .req_base(req_base),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // fields: index, default, len code, base, expected (table byte e*8+b holds 0x40+e*8+b)
  localparam logic [99:0] VEC [8] = '{
    {32'h03020100, 32'hDDCCBBAA, 2'd3, 2'd0, 32'h43424140},
    {32'h1F181007, 32'hDDCCBBAA, 2'd3, 2'd0, 32'h5F585047},
    {32'h08070807, 32'hDDCCBBAA, 2'd0, 2'd0, 32'hDD47BB47},
    {32'hFF20201F, 32'h11223344, 2'd3, 2'd0, 32'h1122335F},
    {32'h0F100F10, 32'h44332211, 2'd1, 2'd0, 32'h4F334F11},
    {32'h18100800, 32'h00000000, 2'd3, 2'd1, 32'h40585048},
    {32'h17180501, 32'hAABBCCDD, 2'd2, 2'd2, 32'h47BB5551},
    {32'h00FE0908, 32'h12345678, 2'd3, 2'd3, 32'h58344140}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic do_lookup(input logic [31:0] ix, input logic [31:0] df, input logic [1:0] ln,
                           input logic [1:0] bs, output logic [31:0] got, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_index = ix; req_default = df; req_len_code = ln; req_base = bs;
    @(negedge clk);
    req_valid = 1'b0;
    got = rsp_data; vld = rsp_valid;
  endtask

  function automatic logic [31:0] ref_model(input logic [31:0] ix, input logic [31:0] df,
                                            input logic [1:0] ln, input logic [1:0] bs);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int b = int'(ix[k*8 +: 8]);
      if (b < (int'(ln) + 1) * 8) begin
        int e = ((b / 8) + int'(bs)) % 4;
        r[k*8 +: 8] = model[e][(b % 8) * 8 +: 8];
      end else begin
        r[k*8 +: 8] = df[k*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    logic        vld;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    req_valid = 1'b0; req_index = '0; req_default = '0; req_len_code = '0; req_base = '0;
    for (int e = 0; e < 4; e++) model[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, cleared table
    chk("R1 valid", 64'(rsp_valid), 64'd0);
    chk("R1 data", 64'(rsp_data), 64'd0);
    do_lookup(32'h18100800, 32'hFFFFFFFF, 2'd3, 2'd0, got, vld);
    chk("R1 table zero", 64'(got), 64'd0);

    // R7: load table, byte e*8+b = 0x40+e*8+b
    for (int e = 0; e < 4; e++) begin
      logic [63:0] v;
      for (int b = 0; b < 8; b++) v[b*8 +: 8] = 8'(8'h40 + e*8 + b);
      do_write(2'(e), v);
    end

    // R3 R4 R5 R6: vector table
    for (int i = 0; i < 8; i++) begin
      do_lookup(VEC[i][99:68], VEC[i][67:36], VEC[i][35:34], VEC[i][33:32], got, vld);
      chk("R3 R4 R5 R6 vector", 64'(got), 64'(VEC[i][31:0]));
      chk("R2 valid after request", 64'(vld), 64'd1);
    end

    // R2 R9: idle cycle after request
    @(negedge clk);
    chk("R2 valid drops", 64'(rsp_valid), 64'd0);
    chk("R9 data held", 64'(rsp_data), 64'h58344140);
    req_index = 32'h01010101; req_default = 32'h99999999;
    @(negedge clk);
    chk("R9 inputs ignored without request", 64'(rsp_data), 64'h58344140);

    // R8: write and lookup in same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 64'h0123456789ABCDEF;
    req_valid = 1'b1; req_index = 32'h00000000; req_default = '0; req_len_code = 2'd3; req_base = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R8 old contents", 64'(rsp_data), 64'h40404040);
    model[0] = 64'h0123456789ABCDEF;
    do_lookup(32'h07000100, 32'h0, 2'd3, 2'd0, got, vld);
    chk("R8 new contents", 64'(got), 64'h01EFCDEF);

    // R4 R6: boundaries per lane, random otherwise
    for (int n = 0; n < 300; n++) begin
      logic [1:0]  ln = 2'($urandom);
      logic [1:0]  bs = 2'($urandom);
      logic [31:0] df = $urandom;
      logic [31:0] ix;
      int lim = (int'(ln) + 1) * 8;
      for (int k = 0; k < 4; k++) begin
        case ($urandom % 5)
          0: ix[k*8 +: 8] = 8'(lim - 1);
          1: ix[k*8 +: 8] = 8'(lim);
          2: ix[k*8 +: 8] = 8'hFF;
          3: ix[k*8 +: 8] = 8'($urandom % 32);
          default: ix[k*8 +: 8] = 8'($urandom);
        endcase
      end
      do_lookup(ix, df, ln, bs, got, vld);
      chk("R4 R5 R6 random", 64'(got), 64'(ref_model(ix, df, ln, bs)));
    end

    // R2: back-to-back requests keep valid high
    @(negedge clk);
    req_valid = 1'b1; req_index = 32'hFFFFFFFF; req_default = 32'hCAFEF00D; req_len_code = 2'd3;
    @(negedge clk);
    req_default = 32'h0BADBEEF;
    chk("R2 back-to-back first", 64'(rsp_data), 64'hCAFEF00D);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 back-to-back valid", 64'(rsp_valid), 64'd1);
    chk("R6 all lanes default", 64'(rsp_data), 64'h0BADBEEF);

    finish_run();
  end
endmodule